// File: doc/BRIEF.md
# Round-Robin Interleaved Add-Compare Array

This block keeps a full-rate stream of add-then-compare results while every copy of the arithmetic updates only once every N clock cycles. An input register takes one operand set (two addends and a threshold) on every clock edge. A free-running phase counter hands each registered set to one of N identical copies in strict rotation. Each copy adds its two addends, compares the sum with its threshold, and holds the outcome in a result register. An N-to-1 selector, steered by the same phase counter, then puts the results back into one output stream in arrival order.

No divided clocks are used. Each copy's input and result registers sit on the main clock and load through an enable that is active in one phase out of N. A valid flag travels with every operand set. The output valid stays low until every copy has captured at least one valid set since the last reset. Synchronous reset returns the phase to zero and clears all flags.

Top module: `rr_split_datapath`

## Requirements
- R1: The input register captures `in_a`, `in_b`, `in_c` and `in_vld` on every rising clock edge, with no gaps.
- R2: The phase counter starts at 0 after reset, steps by one on each edge and wraps from N-1 to 0. On the edge where the phase equals k, copy k, and no other copy, takes the contents of the input register.
- R3: Each result has two fields. `out_sum` is the zero-extended W+1-bit sum `in_a + in_b`. `out_gt` is 1 exactly when that sum is strictly greater than `in_c`, compared unsigned. Where the sum equals `in_c`, `out_gt` is 0.
- R4: Results leave in the order their operands arrived. The operands applied before clock edge e appear on the outputs right after edge e+N+1.
- R5: A copy's operand and result registers change only on the edge where the phase selects that copy. At all other edges they hold.
- R6: Validity is carried with the data. An operand set presented with `in_vld` low produces `out_vld` low in the cycle its result would appear.
- R7: After reset, `out_vld` stays low until every one of the N copies has captured a valid operand set. This holds even when valid results already sit in some copies.
- R8: A synchronous reset forces the phase to 0 and clears every valid flag and every copy's captured-valid record. `out_vld` is low in the cycle after any reset edge.
- R9: A stream with `in_vld` high on every cycle gives `out_vld` high on every cycle once the pipeline is full. Throughput is one result per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | W | First addend |
| in_b | input | W | Second addend |
| in_c | input | W | Threshold compared with the sum |
| in_vld | input | 1 | Operand set is valid |
| out_sum | output | W+1 | Sum of the result now selected |
| out_gt | output | 1 | Sum of that result is greater than its threshold |
| out_vld | output | 1 | Output fields are valid |

## Verification
The two functions that can coincide are a copy's first valid capture and the selector reaching an earlier copy whose valid result is already waiting. In that cycle the gate on `out_vld` opens just as real data arrives at the output. The bench provokes this with an operand stream in which every set bound for the last copy is marked invalid for several rotations, and only then turns valid. The expected `out_vld` comes from a behavioural record of which copies have been primed. The bench requires `out_vld` to stay low throughout the withheld stretch. It must then rise on exactly the first cycle the model allows, with data in arrival order. A reset in the middle of a stream is also checked against the same model.

// File: rtl/rr_split_datapath.sv
module rr_split_datapath #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  input  logic         in_vld,
  output logic [W:0]   out_sum,
  output logic         out_gt,
  output logic         out_vld
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0] ph, sel;
  logic [W-1:0]  iq_a, iq_b, iq_c;
  logic          iq_v;
  logic [N-1:0]  ld;

  logic [W-1:0]  cp_a [N];
  logic [W-1:0]  cp_b [N];
  logic [W-1:0]  cp_c [N];
  logic [N-1:0]  cp_v;
  logic [W:0]    rs_sum [N];
  logic [N-1:0]  rs_gt;
  logic [N-1:0]  rs_v;
  logic [N-1:0]  prm;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= (ph == LAST) ? '0 : ph + PW'(1);
  end

  always_ff @(posedge clk) begin
    iq_a <= in_a;
    iq_b <= in_b;
    iq_c <= in_c;
    iq_v <= rst ? 1'b0 : in_vld;
  end

  for (genvar k = 0; k < N; k++) begin : g_ld
    assign ld[k] = (ph == PW'(k));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (ld[k]) begin
        cp_a[k]   <= iq_a;
        cp_b[k]   <= iq_b;
        cp_c[k]   <= iq_c;
        rs_sum[k] <= {1'b0, cp_a[k]} + {1'b0, cp_b[k]};
        rs_gt[k]  <= ({1'b0, cp_a[k]} + {1'b0, cp_b[k]}) > {1'b0, cp_c[k]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_v <= '0;
      rs_v <= '0;
      prm  <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (ld[k]) begin
          cp_v[k] <= iq_v;
          rs_v[k] <= cp_v[k];
          prm[k]  <= prm[k] | iq_v;
        end
      end
    end
  end

  assign sel     = (ph == '0) ? LAST : ph - PW'(1);
  assign out_sum = rs_sum[sel];
  assign out_gt  = rs_gt[sel];
  assign out_vld = rs_v[sel] & (&prm);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph == LAST) |=> (ph == '0)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ph != LAST) |=> (ph == $past(ph) + PW'(1))); // R2
  AST_ONE_LOADER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_vld); // R8

  for (genvar k = 0; k < N; k++) begin : g_hold
    AST_COPY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ph != PW'(k)) |=> ($stable(rs_sum[k]) && $stable(cp_a[k]) && $stable(cp_c[k]))); // R5
  end
endmodule

// File: tb/rr_split_datapath_tb_top.sv
module rr_split_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic in_vld = 1'b0;
  logic [W:0] out_sum;
  logic out_gt, out_vld;

  int total = 0;
  int bad = 0;

  logic [W-1:0] qa[$];
  logic [W-1:0] qb[$];
  logic [W-1:0] qc[$];
  logic         qv[$];
  logic [N-1:0] primed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_split_datapath #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .in_vld(in_vld), .out_sum(out_sum), .out_gt(out_gt), .out_vld(out_vld)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] c, input logic v, input logic r,
                      input string tag);
    int n, q;
    logic [W:0] es;
    logic ev;
    in_a = a; in_b = b; in_c = c; in_vld = v; rst = r;
    if (!r) begin
      qa.push_back(a); qb.push_back(b); qc.push_back(c); qv.push_back(v);
    end
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      qa.delete(); qb.delete(); qc.delete(); qv.delete();
      primed = '0;
      chk(out_vld == 1'b0, "R8", "out_vld during reset", int'(out_vld), 0);
    end else begin
      n = qa.size() - 1;
      if (n >= 1 && qv[n-1]) primed[n % N] = 1'b1;
      q = n - N - 1;
      ev = (q >= 0) ? (qv[q] && (&primed)) : 1'b0;
      chk(out_vld == ev, tag, "out_vld (R6 R7)", int'(out_vld), int'(ev));
      if (ev) begin
        es = {1'b0, qa[q]} + {1'b0, qb[q]};
        chk(out_sum == es, tag, "out_sum (R3 R4 R5)", int'(out_sum), int'(es));
        chk(out_gt == (es > {1'b0, qc[q]}), tag, "out_gt (R3)",
            int'(out_gt), int'(es > {1'b0, qc[q]}));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 3; i++) step('0, '0, '0, 1'b1, 1'b1, "R8");

    // R1 R2 R4 R9: back-to-back valid stream of random operands
    for (int i = 0; i < 60; i++)
      step(W'($urandom), W'($urandom), W'($urandom), 1'b1, 1'b0, "R9");

    // R3: boundary values
    step('1, '1, '1, 1'b1, 1'b0, "R3");
    step(8'd10, 8'd20, 8'd30, 1'b1, 1'b0, "R3");
    step(8'd10, 8'd20, 8'd29, 1'b1, 1'b0, "R3");
    step('0, '0, '0, 1'b1, 1'b0, "R3");
    step(8'd128, 8'd128, 8'd255, 1'b1, 1'b0, "R3");
    for (int i = 0; i < N + 2; i++) step('0, '0, '0, 1'b0, 1'b0, "R6");

    // R7: withhold valid data from the last copy after a fresh reset
    for (int i = 0; i < 2; i++) step('0, '0, '0, 1'b1, 1'b1, "R8");
    for (int s = 0; s < 40; s++)
      step(W'($urandom), W'($urandom), W'($urandom),
           (((s + 1) % N) != N - 1) || (s >= 24), 1'b0, "R7");

    // R6: alternating validity
    for (int s = 0; s < 30; s++)
      step(W'($urandom), W'($urandom), W'($urandom), s[1], 1'b0, "R6");

    // R8 R2: reset in the middle of a stream, then resume
    step(8'd1, 8'd2, 8'd3, 1'b1, 1'b1, "R8");
    for (int s = 0; s < 30; s++)
      step(W'($urandom), W'($urandom), W'($urandom), 1'b1, 1'b0, "R2");
    for (int s = 0; s < N + 2; s++) step('0, '0, '0, 1'b0, 1'b0, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule